// File: doc/BRIEF.md
# Flash-Bypass Gang Programming Bus Sequencer

This block sits on the host side of a gang programmer. The target device has its flash controller bypassed. All flash control lines are reached through a narrow register port on the target: a 3-bit select picks an internal register, and an 8-bit data bus carries the value. The target latches the value on the rising edge of a bus clock that the host drives. The sequencer turns one high-level command into the exact series of register writes and waits that the flash array needs.

A command gives a start address, a byte count and a direction. A program command takes its bytes from a valid/ready write-data stream. It opens the row, stores each byte with a column-enable pulse of programming length, then closes the row and waits out the recovery time. A read command opens the row for sensing. For each byte it releases the data bus, clocks the output register and sends the sampled byte out on a valid/ready read-data stream.

Back-pressure rules are as follows. A command is accepted only when `cmd_valid` and `cmd_ready` are both high at a clock edge. The sequencer waits at the data step for as long as `wdat_valid` is low, and no bus activity takes place meanwhile. A read byte stays on `rdat_data`, with `rdat_valid` high, until `rdat_ready` is seen high, and the bus stays quiet meanwhile. All waits are whole host-clock cycle counts set by parameters.

Top module: `gang_bus_sequencer`

## Requirements
- R1: After reset, `cmd_ready`=1, `busy`=0, `bus_clk`=0, `bus_oe`=0, `rdat_valid`=0, `wdat_ready`=0, `bus_sel`=000 and `bus_dout`=0x00.
- R2: For every register write, `bus_sel`/`bus_dout` settle at least SETUP_CYC cycles before `bus_clk` rises. `bus_clk` is high for exactly one cycle, and select and data stay unchanged for one cycle after it falls.
- R3: The first command after reset is preceded by a single write of 0x80 to select 100 (test mode). Later commands never repeat it.
- R4: A program command begins with these writes in order: select 000 = address[15:8], select 001 = address[7:0], select 011 = 0x84, a wait of at least NVS_CYC cycles, select 011 = 0x85, and a wait of at least PGS_CYC cycles.
- R5: For each byte, a program command writes select 001 = current low address, select 010 = next stream byte, select 011 = 0xC5, waits at least PROG_CYC cycles, then writes select 011 = 0x85.
- R6: After the last byte, a program command writes select 011 = 0x81, waits at least NVS_CYC cycles, writes select 011 = 0x00, and waits at least RCV_CYC cycles before `cmd_ready` returns.
- R7: Between bytes only the low log2(ROW_BYTES) bits of the low address (bits [5:0] by default) increment, wrapping within the row. Address bits [7:6] and the high byte stay the same for the whole command.
- R8: A read command writes select 000, select 001, then select 011 = 0xF0, and waits at least RD_CYC cycles. Each byte then gets a select 101 bus clock with `bus_oe`=0, and the byte is sampled from `bus_din` after that clock. Each later byte first rewrites select 001 with the incremented address and waits RD_CYC. The command ends with select 011 = 0x00.
- R9: While `wdat_valid` is low at the data step, `wdat_ready` stays high and no bus clock is issued.
- R10: While `rdat_valid` is high and `rdat_ready` is low, `rdat_data` is held and no bus clock is issued.
- R11: `cmd_ready` is high only when idle and `busy` is its complement. `cmd_len` holds the byte count minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_write | input | 1 | 1 = program, 0 = read |
| cmd_addr | input | 16 | Start byte address |
| cmd_len | input | 6 | Byte count minus one |
| wdat_valid | input | 1 | Program byte offered |
| wdat_ready | output | 1 | Program byte taken |
| wdat_data | input | 8 | Program byte |
| rdat_valid | output | 1 | Read byte offered |
| rdat_ready | input | 1 | Read byte taken |
| rdat_data | output | 8 | Read byte |
| bus_sel | output | 3 | Target register select |
| bus_dout | output | 8 | Data driven to the target |
| bus_oe | output | 1 | Host drives the data bus when high |
| bus_din | input | 8 | Data returned by the target |
| bus_clk | output | 1 | Register latch clock to the target |
| busy | output | 1 | Command in progress |

## Verification
The assertions assume that `rst_n` is held low across at least one clock edge before any traffic, and that `bus_din` changes only as the target's response to a select-101 bus clock. The bench's target model keeps to this: it updates its output byte only in the cycle where it sees such a clock, and it latches addresses only from driven select-000/001 writes. The stream inputs are left free, so the handshake checks must hold under the stalls the bench inserts on purpose. Command fields are driven only for the one accepting cycle and then cleared, which shows that the block works from its own copy of them.

// File: rtl/gbs_pkg.sv
package gbs_pkg;
  localparam int BUS_W = 8;
  localparam int SEL_W = 3;

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [BUS_W-1:0] byte_t;

  localparam sel_t SEL_XHI  = 3'd0;
  localparam sel_t SEL_XLO  = 3'd1;
  localparam sel_t SEL_WDAT = 3'd2;
  localparam sel_t SEL_CTRL = 3'd3;
  localparam sel_t SEL_TEST = 3'd4;
  localparam sel_t SEL_RDAT = 3'd5;

  localparam byte_t CB_TEST    = 8'h80;
  localparam byte_t CB_ROWPROG = 8'h84;
  localparam byte_t CB_STORE   = 8'h85;
  localparam byte_t CB_COLON   = 8'hC5;
  localparam byte_t CB_UNPROG  = 8'h81;
  localparam byte_t CB_OFF     = 8'h00;
  localparam byte_t CB_SENSE   = 8'hF0;

  typedef enum logic [4:0] {
    ST_IDLE, ST_TEST, ST_AHI, ST_ALO, ST_PROG, ST_STORE, ST_BLO, ST_BDAT,
    ST_COLON, ST_COLOFF, ST_UNPROG, ST_CLOSE, ST_RCTL, ST_RSEL, ST_ROUT,
    ST_RLO, ST_REND
  } st_t;

  typedef enum logic [1:0] {PH_GO, PH_WR, PH_TM} ph_t;
endpackage

// File: rtl/gbs_bus_writer.sv
module gbs_bus_writer
  import gbs_pkg::*;
#(
  parameter int SETUP_CYC = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req,
  input  sel_t  req_sel,
  input  byte_t req_data,
  input  logic  req_drive,
  output sel_t  bus_sel,
  output byte_t bus_dout,
  output logic  bus_oe,
  output logic  bus_clk,
  output logic  done
);
  localparam int CW = $clog2(SETUP_CYC + 1) + 1;

  typedef enum logic [1:0] {W_IDLE, W_SET, W_HI, W_HOLD} wph_t;
  wph_t          ph;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= W_IDLE;
      cnt      <= '0;
      bus_sel  <= SEL_XHI;
      bus_dout <= '0;
      bus_oe   <= 1'b0;
      bus_clk  <= 1'b0;
    end else begin
      case (ph)
        W_IDLE: if (req) begin
          bus_sel  <= req_sel;
          bus_dout <= req_data;
          bus_oe   <= req_drive;
          cnt      <= CW'(SETUP_CYC);
          ph       <= W_SET;
        end
        W_SET: begin
          if (cnt <= CW'(1)) begin
            bus_clk <= 1'b1;
            ph      <= W_HI;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        W_HI: begin
          bus_clk <= 1'b0;
          ph      <= W_HOLD;
        end
        default: ph <= W_IDLE;
      endcase
    end
  end

  assign done = (ph == W_HOLD);

  // R2
  clk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clk |=> !bus_clk);
  // R2
  setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_clk) |-> ($stable(bus_sel) && $stable(bus_dout) && $stable(bus_oe)));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_clk) |-> ($stable(bus_sel) && $stable(bus_dout)));
  // R8
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_clk && bus_sel == SEL_RDAT) |-> !bus_oe);
endmodule

// File: rtl/gbs_wait_timer.sv
module gbs_wait_timer #(
  parameter int TW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          busy
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - TW'(1);
  end

  assign busy = (cnt != '0);

  // R4
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt == '0));
endmodule

// File: rtl/gbs_seq_ctrl.sv
module gbs_seq_ctrl
  import gbs_pkg::*;
#(
  parameter int ROW_BYTES = 64,
  parameter int LEN_W     = 6,
  parameter int TW        = 11,
  parameter int NVS_CYC   = 250,
  parameter int PGS_CYC   = 500,
  parameter int PROG_CYC  = 1500,
  parameter int RCV_CYC   = 50,
  parameter int RD_CYC    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_write,
  input  logic [15:0]      cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             wdat_valid,
  output logic             wdat_ready,
  input  byte_t            wdat_data,
  output logic             rdat_valid,
  input  logic             rdat_ready,
  output byte_t            rdat_data,
  output logic             wr_req,
  output sel_t             wr_sel,
  output byte_t            wr_data,
  output logic             wr_drive,
  input  logic             wr_done,
  input  byte_t            bus_din,
  output logic             tm_load,
  output logic [TW-1:0]    tm_val,
  input  logic             tm_busy,
  output logic             busy
);
  localparam byte_t YMASK = byte_t'(ROW_BYTES - 1);

  st_t              st, nxt;
  ph_t              ph;
  logic             tmode_done, is_wr, adv, bump;
  byte_t            addr_hi, addr_lo, rd_q;
  logic [LEN_W-1:0] rem;

  always_comb begin
    wr_sel   = SEL_CTRL;
    wr_data  = CB_OFF;
    wr_drive = 1'b1;
    tm_val   = '0;
    case (st)
      ST_TEST:   begin wr_sel = SEL_TEST; wr_data = CB_TEST; end
      ST_AHI:    begin wr_sel = SEL_XHI;  wr_data = addr_hi; end
      ST_ALO:    begin wr_sel = SEL_XLO;  wr_data = addr_lo; end
      ST_PROG:   begin wr_data = CB_ROWPROG; tm_val = TW'(NVS_CYC); end
      ST_STORE:  begin wr_data = CB_STORE;   tm_val = TW'(PGS_CYC); end
      ST_BLO:    begin wr_sel = SEL_XLO;  wr_data = addr_lo; end
      ST_BDAT:   begin wr_sel = SEL_WDAT; wr_data = wdat_data; end
      ST_COLON:  begin wr_data = CB_COLON;   tm_val = TW'(PROG_CYC); end
      ST_COLOFF: wr_data = CB_STORE;
      ST_UNPROG: begin wr_data = CB_UNPROG;  tm_val = TW'(NVS_CYC); end
      ST_CLOSE:  begin wr_data = CB_OFF;     tm_val = TW'(RCV_CYC); end
      ST_RCTL:   begin wr_data = CB_SENSE;   tm_val = TW'(RD_CYC); end
      ST_RLO:    begin wr_sel = SEL_XLO; wr_data = addr_lo; tm_val = TW'(RD_CYC); end
      ST_RSEL:   begin wr_sel = SEL_RDAT; wr_drive = 1'b0; end
      default:   ;
    endcase
  end

  always_comb begin
    case (st)
      ST_TEST:   nxt = ST_AHI;
      ST_AHI:    nxt = ST_ALO;
      ST_ALO:    nxt = is_wr ? ST_PROG : ST_RCTL;
      ST_PROG:   nxt = ST_STORE;
      ST_STORE:  nxt = ST_BLO;
      ST_BLO:    nxt = ST_BDAT;
      ST_BDAT:   nxt = ST_COLON;
      ST_COLON:  nxt = ST_COLOFF;
      ST_COLOFF: nxt = (rem == '0) ? ST_UNPROG : ST_BLO;
      ST_UNPROG: nxt = ST_CLOSE;
      ST_RCTL:   nxt = ST_RSEL;
      ST_RSEL:   nxt = ST_ROUT;
      ST_ROUT:   nxt = (rem == '0) ? ST_REND : ST_RLO;
      ST_RLO:    nxt = ST_RSEL;
      default:   nxt = ST_IDLE;
    endcase
  end

  assign wr_req  = (ph == PH_GO) && (st != ST_IDLE) && (st != ST_ROUT) &&
                   ((st != ST_BDAT) || wdat_valid);
  assign tm_load = (ph == PH_WR) && wr_done && (tm_val != '0);
  assign adv     = (st == ST_ROUT) ? rdat_ready :
                   (((ph == PH_WR) && wr_done && (tm_val == '0)) ||
                    ((ph == PH_TM) && !tm_busy));
  assign bump    = ((st == ST_COLOFF) || (st == ST_ROUT)) && (rem != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= PH_GO; tmode_done <= 1'b0; is_wr <= 1'b0;
      addr_hi <= '0; addr_lo <= '0; rem <= '0; rd_q <= '0;
    end else if (st == ST_IDLE) begin
      if (cmd_valid) begin
        is_wr      <= cmd_write;
        addr_hi    <= cmd_addr[15:8];
        addr_lo    <= cmd_addr[7:0];
        rem        <= cmd_len;
        st         <= tmode_done ? ST_AHI : ST_TEST;
        tmode_done <= 1'b1;
        ph         <= PH_GO;
      end
    end else if (adv) begin
      st <= nxt;
      ph <= PH_GO;
      if (st == ST_RSEL) rd_q <= bus_din;
      if (bump) begin
        rem     <= rem - LEN_W'(1);
        addr_lo <= (addr_lo & ~YMASK) | ((addr_lo + byte_t'(1)) & YMASK);
      end
    end else begin
      case (ph)
        PH_GO:   if (wr_req) ph <= PH_WR;
        PH_WR:   if (tm_load) ph <= PH_TM;
        default: ;
      endcase
    end
  end

  assign cmd_ready  = (st == ST_IDLE);
  assign busy       = (st != ST_IDLE);
  assign wdat_ready = (st == ST_BDAT) && (ph == PH_GO);
  assign rdat_valid = (st == ST_ROUT);
  assign rdat_data  = rd_q;

  // R10
  rdat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdat_valid && !rdat_ready) |=> (rdat_valid && $stable(rdat_data)));
  // R7
  row_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(addr_hi) && $stable(addr_lo & ~YMASK)));
  // R9
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdat_ready && !wdat_valid) |=> wdat_ready);
endmodule

// File: rtl/gang_bus_sequencer.sv
module gang_bus_sequencer
  import gbs_pkg::*;
#(
  parameter int ROW_BYTES = 64,
  parameter int SETUP_CYC = 1,
  parameter int NVS_CYC   = 250,
  parameter int PGS_CYC   = 500,
  parameter int PROG_CYC  = 1500,
  parameter int RCV_CYC   = 50,
  parameter int RD_CYC    = 3,
  parameter int LEN_W     = $clog2(ROW_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_write,
  input  logic [15:0]      cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             wdat_valid,
  output logic             wdat_ready,
  input  logic [7:0]       wdat_data,
  output logic             rdat_valid,
  input  logic             rdat_ready,
  output logic [7:0]       rdat_data,
  output logic [2:0]       bus_sel,
  output logic [7:0]       bus_dout,
  output logic             bus_oe,
  input  logic [7:0]       bus_din,
  output logic             bus_clk,
  output logic             busy
);
  localparam int M1   = (NVS_CYC > PGS_CYC) ? NVS_CYC : PGS_CYC;
  localparam int M2   = (PROG_CYC > RCV_CYC) ? PROG_CYC : RCV_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXW = (M3 > RD_CYC) ? M3 : RD_CYC;
  localparam int TW   = $clog2(MAXW + 1);

  logic          wr_req, wr_drive, wr_done, tm_load, tm_busy;
  sel_t          wr_sel;
  byte_t         wr_data;
  logic [TW-1:0] tm_val;

  gbs_seq_ctrl #(
    .ROW_BYTES(ROW_BYTES), .LEN_W(LEN_W), .TW(TW), .NVS_CYC(NVS_CYC),
    .PGS_CYC(PGS_CYC), .PROG_CYC(PROG_CYC), .RCV_CYC(RCV_CYC), .RD_CYC(RD_CYC)
  ) u_ctrl (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_write, .cmd_addr, .cmd_len,
    .wdat_valid, .wdat_ready, .wdat_data, .rdat_valid, .rdat_ready, .rdat_data,
    .wr_req, .wr_sel, .wr_data, .wr_drive, .wr_done, .bus_din,
    .tm_load, .tm_val, .tm_busy, .busy
  );

  gbs_bus_writer #(.SETUP_CYC(SETUP_CYC)) u_writer (
    .clk, .rst_n, .req(wr_req), .req_sel(wr_sel), .req_data(wr_data),
    .req_drive(wr_drive), .bus_sel, .bus_dout, .bus_oe, .bus_clk, .done(wr_done)
  );

  gbs_wait_timer #(.TW(TW)) u_timer (
    .clk, .rst_n, .load(tm_load), .load_val(tm_val), .busy(tm_busy)
  );

  // R11
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !bus_clk);
endmodule

// File: tb/test_gang_bus_sequencer.sv
module test_gang_bus_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int ROW = 64, LW = 6;
  localparam int NVS = 250, PGS = 500, PRG = 1500, RCV = 50, RDW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [15:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic wdat_valid = 1'b0, rdat_ready = 1'b0;
  logic [7:0] wdat_data = '0;
  logic cmd_ready, wdat_ready, rdat_valid, bus_oe, bus_clk, busy;
  logic [7:0] rdat_data, bus_dout, bus_din;
  logic [2:0] bus_sel;

  gang_bus_sequencer #(
    .ROW_BYTES(ROW), .SETUP_CYC(1), .NVS_CYC(NVS), .PGS_CYC(PGS),
    .PROG_CYC(PRG), .RCV_CYC(RCV), .RD_CYC(RDW)
  ) i_gang_bus_sequencer (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;

  // target model and bus log
  logic [2:0] lg_sel [0:255];
  logic [7:0] lg_dat [0:255];
  logic       lg_oe  [0:255];
  int         lg_cyc [0:255];
  int         lg_n = 0;
  logic [7:0] t_hi = '0, t_lo = '0, t_din = '0;
  assign bus_din = t_din;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (rst_n && bus_clk) begin
      lg_sel[lg_n] <= bus_sel;
      lg_dat[lg_n] <= bus_dout;
      lg_oe[lg_n]  <= bus_oe;
      lg_cyc[lg_n] <= cyc;
      lg_n <= lg_n + 1;
      if (bus_oe && bus_sel == 3'd0) t_hi <= bus_dout;
      if (bus_oe && bus_sel == 3'd1) t_lo <= bus_dout;
      if (bus_sel == 3'd5) t_din <= pat({t_hi, t_lo});
    end
  end

  // write-data source
  logic [7:0] wbuf [0:63];
  int wsent = 0, wtotal = 0;
  logic feed_hold = 1'b0;
  always @(posedge clk) if (wdat_valid && wdat_ready) wsent <= wsent + 1;
  always @(negedge clk) begin
    wdat_valid = !feed_hold && (wsent < wtotal);
    wdat_data  = wbuf[wsent % 64];
  end

  // read-data sink
  logic [7:0] rbuf [0:63];
  int rcnt = 0;
  always @(posedge clk) if (rdat_valid && rdat_ready) begin
    rbuf[rcnt % 64] <= rdat_data;
    rcnt <= rcnt + 1;
  end

  // expected write list
  logic [2:0] ex_sel [0:255];
  logic [7:0] ex_dat [0:255];
  int         ex_gap [0:255];
  logic       ex_cd  [0:255];
  string      ex_req [0:255];
  int         ex_n;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] s, input logic [7:0] d, input int gap,
                      input bit cd, input string req);
    ex_sel[ex_n] = s; ex_dat[ex_n] = d; ex_gap[ex_n] = gap;
    ex_cd[ex_n] = cd; ex_req[ex_n] = req;
    ex_n++;
  endtask

  task automatic compare_log(input int base);
    int got;
    got = lg_n - base;
    check(got == ex_n, {ex_req[0], " write count"}, got, ex_n);
    for (int k = 0; k < ex_n && k < got; k++) begin
      check(lg_sel[base+k] == ex_sel[k], {ex_req[k], " select"}, lg_sel[base+k], ex_sel[k]);
      if (ex_cd[k])
        check(lg_dat[base+k] == ex_dat[k], {ex_req[k], " data"}, lg_dat[base+k], ex_dat[k]);
      else
        check(lg_oe[base+k] == 1'b0, "R8 bus released", lg_oe[base+k], 0);
      if (ex_gap[k] > 0 && k + 1 < got)
        check(lg_cyc[base+k+1] - lg_cyc[base+k] >= ex_gap[k], {ex_req[k], " wait"},
              lg_cyc[base+k+1] - lg_cyc[base+k], ex_gap[k]);
    end
  endtask

  task automatic issue(input bit wr, input logic [15:0] a, input int nb);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_len = LW'(nb - 1);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_addr = '0; cmd_len = '0; cmd_write = 1'b0;
    check(cmd_ready == 1'b0 && busy == 1'b1, "R11 busy after accept", cmd_ready, 0);
  endtask

  task automatic wait_idle(output int c);
    do @(negedge clk); while (!cmd_ready);
    c = cyc;
  endtask

  task automatic t_reset();
    check(cmd_ready == 1'b1 && busy == 1'b0, "R1 ready", {cmd_ready, busy}, 2);
    check(bus_clk == 1'b0 && bus_oe == 1'b0, "R1 bus idle", {bus_clk, bus_oe}, 0);
    check(rdat_valid == 1'b0 && wdat_ready == 1'b0, "R1 streams", {rdat_valid, wdat_ready}, 0);
    check(bus_sel == 3'd0 && bus_dout == 8'h00, "R1 bus value", {bus_sel, bus_dout}, 0);
    check(lg_n == 0, "R1 no writes", lg_n, 0);
  endtask

  task automatic t_write(input logic [15:0] a, input int nb, input bit first, input bit stall);
    int base, k, c;
    logic [7:0] lo, d;
    base = lg_n; ex_n = 0; lo = a[7:0];
    if (first) push(3'd4, 8'h80, 0, 1, "R3");
    push(3'd0, a[15:8], 0, 1, "R4");
    push(3'd1, lo, 0, 1, "R4");
    push(3'd3, 8'h84, NVS, 1, "R4");
    push(3'd3, 8'h85, PGS, 1, "R4");
    for (int i = 0; i < nb; i++) begin
      d = 8'h3C ^ 8'(i * 29) ^ a[7:0];
      wbuf[(wtotal + i) % 64] = d;
      push(3'd1, lo, 0, 1, "R7");
      push(3'd2, d, 0, 1, "R5");
      push(3'd3, 8'hC5, PRG, 1, "R5");
      push(3'd3, 8'h85, 0, 1, "R5");
      lo = {lo[7:6], lo[5:0] + 6'd1};
    end
    push(3'd3, 8'h81, NVS, 1, "R6");
    push(3'd3, 8'h00, 0, 1, "R6");
    feed_hold = stall;
    wtotal = wtotal + nb;
    issue(1'b1, a, nb);
    if (stall) begin
      do @(negedge clk); while (!wdat_ready);
      k = lg_n;
      repeat (100) @(negedge clk);
      check(wdat_ready == 1'b1, "R9 ready held", wdat_ready, 1);
      check(lg_n == k, "R9 no bus write while starved", lg_n, k);
      feed_hold = 1'b0;
    end
    wait_idle(c);
    check(c - lg_cyc[lg_n-1] >= RCV, "R6 recovery", c - lg_cyc[lg_n-1], RCV);
    compare_log(base);
  endtask

  task automatic t_read(input logic [15:0] a, input int nb, input bit stall);
    int base, rbase, k, c;
    logic [7:0] lo, v;
    logic [7:0] er [0:63];
    base = lg_n; rbase = rcnt; ex_n = 0; lo = a[7:0];
    push(3'd0, a[15:8], 0, 1, "R8");
    push(3'd1, lo, 0, 1, "R8");
    push(3'd3, 8'hF0, RDW, 1, "R8");
    push(3'd5, 8'h00, 0, 0, "R8");
    er[0] = pat({a[15:8], lo});
    for (int i = 1; i < nb; i++) begin
      lo = {lo[7:6], lo[5:0] + 6'd1};
      er[i] = pat({a[15:8], lo});
      push(3'd1, lo, RDW, 1, "R7");
      push(3'd5, 8'h00, 0, 0, "R8");
    end
    push(3'd3, 8'h00, 0, 1, "R8");
    rdat_ready = !stall;
    issue(1'b0, a, nb);
    if (stall) begin
      do @(negedge clk); while (!rdat_valid);
      v = rdat_data; k = lg_n;
      repeat (40) @(negedge clk);
      check(rdat_valid == 1'b1, "R10 valid held", rdat_valid, 1);
      check(rdat_data == v, "R10 data held", rdat_data, v);
      check(lg_n == k, "R10 no bus write while blocked", lg_n, k);
      check(v == er[0], "R8 first byte", v, er[0]);
      rdat_ready = 1'b1;
    end
    wait_idle(c);
    compare_log(base);
    check(rcnt - rbase == nb, "R8 byte count", rcnt - rbase, nb);
    for (int i = 0; i < nb && i < rcnt - rbase; i++)
      check(rbuf[(rbase + i) % 64] == er[i], "R8 read data", rbuf[(rbase + i) % 64], er[i]);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(16'h1234, 3, 1'b1, 1'b1);
    t_write(16'hA5BE, 4, 1'b0, 1'b0);
    t_read(16'h0A7E, 3, 1'b1);
    t_read(16'h5501, 1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule